// File: doc/BRIEF.md
# SPI DDR Data-Eye Trainer

This block is the host-side calibration engine for a double-data-rate serial read. While the flash device drives its programmable 8-bit learning pattern during the final dummy cycles, the host samples every active IO line at up to sixteen candidate capture phases. Each phase arrives on its own strobe, one strobe per half clock. The trainer compares each phase's samples against the pattern and keeps a per-phase pass/fail record. The pattern mixes slow and fast rising and falling transitions, so a phase passes only if it sits inside the whole valid eye.

After the learning window the trainer latches a pass bitmap. It then walks the bitmap one phase per cycle to find the longest run of passing phases, and moves the capture phase to the middle of that run. If no phase passed, it raises an error flag and keeps the capture phase it already had. A one-cycle done pulse marks the end of each training pass.

Top module: `eye_trainer`

## Requirements
- R1: After reset, `passMap` is 0, `chosenPhase` equals DEFAULT_PHASE (8), `errFlag` is 0 and `trainDone` is 0.
- R2: A `trainStart` pulse while idle clears every per-phase record and opens the learning window. Phase strobes outside the window are ignored.
- R3: For each phase, the k-th strobe (k = 0..7) in a window is compared against pattern bit 7-k, most significant bit first.
- R4: `laneMode` 00 compares lane 0 only, 01 compares lanes 0 and 1, and 10 or 11 compares all four lanes. A mismatch on an inactive lane has no effect on the result.
- R5: A phase passes only if it received at least 8 strobes in the window and every active lane matched on each of the first 8. Strobes after the 8th are ignored, and fewer than 8 strobes is a fail.
- R6: Bit i of `passMap` is the result of phase i. It is loaded in the cycle `trainEnd` is sampled during the window and is held until the next `trainEnd`. Strobes that arrive in the `trainEnd` cycle are not counted.
- R7: When at least one phase passes, `chosenPhase` becomes start + (length-1)/2 of the longest run of consecutive passing phases. When runs tie in length, the lowest-indexed run wins. `errFlag` is cleared.
- R8: When no phase passes, `errFlag` is set and `chosenPhase` keeps its previous value.
- R9: `trainDone` is a single-cycle pulse that is first visible NPH+1 (17) clock edges after the edge that samples `trainEnd`. `trainStart` and `trainEnd` pulses during the selection are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trainStart | input | 1 | Opens a learning window when idle |
| trainEnd | input | 1 | Closes the window and starts the selection |
| learnPattern | input | 8 | Expected learning pattern, MSB first |
| laneMode | input | 2 | Active lane count: 00 x1, 01 x2, 1x x4 |
| phaseStrobe | input | 16 | One strobe per candidate phase, one per half clock |
| phaseSample | input | 64 | Sampled lanes; phase i lanes at [4i+3:4i] |
| passMap | output | 16 | Latched per-phase pass bitmap |
| chosenPhase | output | 4 | Selected capture phase |
| errFlag | output | 1 | Last training found no passing phase |
| trainDone | output | 1 | One-cycle pulse when selection finishes |

## Verification
All phases receive the clean pattern 34h, which exposes any bit-order or count mistake as a phase that fails when it should pass. A bit-reversed drive of the same pattern makes every phase fail, which shows the bits are compared MSB first and exercises the error path. Corruptions on a single lane with changing lane counts show whether lane masking is correct. Bitmaps with one interior eye, two equal eyes, or a truncated or overlong beat count separate the midpoint, tie-break and strobe-count rules.

// File: rtl/eye_trainer_pkg.sv
package eye_trainer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_SCAN    = 2'd2,
    ST_FINISH  = 2'd3
  } trainState_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic clearAll;
    logic beatEnable;
    logic latchMap;
    logic scanInit;
    logic scanStep;
    logic commit;
  } ctrlStrobe_t;

  localparam int PAT_W = 8;

endpackage

// File: rtl/eye_trainer_ctrl.sv
module eye_trainer_ctrl
  import eye_trainer_pkg::*;
#(
  parameter int NPH  = 16,
  parameter int PH_W = $clog2(NPH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trainStart,
  input  logic            trainEnd,
  output ctrlStrobe_t     strobe,
  output logic [PH_W-1:0] scanIdx,
  output logic            trainDone
);

  localparam logic [PH_W-1:0] LAST_IDX = PH_W'(NPH - 1);

  trainState_t     state, stateNext;
  logic [PH_W-1:0] stepCnt;
  logic            doneQ;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (trainStart) begin
          strobe.clearAll = 1'b1;
          stateNext       = ST_COLLECT;
        end
      end
      ST_COLLECT: begin
        if (trainEnd) begin
          strobe.latchMap = 1'b1;
          strobe.scanInit = 1'b1;
          stateNext       = ST_SCAN;
        end else begin
          strobe.beatEnable = 1'b1;
        end
      end
      ST_SCAN: begin
        strobe.scanStep = 1'b1;
        if (stepCnt == LAST_IDX) stateNext = ST_FINISH;
      end
      ST_FINISH: begin
        strobe.commit = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= strobe.commit;
      if (strobe.scanInit)      stepCnt <= '0;
      else if (strobe.scanStep) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign scanIdx   = stepCnt;
  assign trainDone = doneQ;

  // R9: done lasts exactly one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    trainDone |=> !trainDone);

  // R9: phases of the sequence never overlap
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clearAll, strobe.latchMap, strobe.scanStep, strobe.commit}));

  // R9: a commit is followed by the done pulse
  a_r9_commit_done: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> trainDone);

endmodule

// File: rtl/eye_trainer_dp.sv
module eye_trainer_dp
  import eye_trainer_pkg::*;
#(
  parameter int NPH           = 16,
  parameter int LANES         = 4,
  parameter int DEFAULT_PHASE = 8,
  parameter int PH_W          = $clog2(NPH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [PH_W-1:0]        scanIdx,
  input  logic [PAT_W-1:0]       learnPattern,
  input  logic [1:0]             laneMode,
  input  logic [NPH-1:0]         phaseStrobe,
  input  logic [NPH*LANES-1:0]   phaseSample,
  output logic [NPH-1:0]         passMap,
  output logic [PH_W-1:0]        chosenPhase,
  output logic                   errFlag
);

  localparam int CNT_W  = $clog2(PAT_W + 1);
  localparam int PIDX_W = $clog2(PAT_W);
  localparam int LEN_W  = $clog2(NPH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAT_W);

  // Active-lane mask
  logic [LANES-1:0] laneMask;
  int               activeLanes;

  always_comb begin
    unique case (laneMode)
      2'b00:   activeLanes = 1;
      2'b01:   activeLanes = 2;
      default: activeLanes = 4;
    endcase
    for (int l = 0; l < LANES; l++) laneMask[l] = (l < activeLanes);
  end

  // Per-phase comparators
  logic [NPH-1:0] phasePass;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic [CNT_W-1:0]  beatCnt;
    logic              badQ;
    logic [PIDX_W-1:0] bitIdx;
    logic              bitExp;
    logic              mismatch;

    assign bitIdx   = PIDX_W'(PAT_W - 1) - beatCnt[PIDX_W-1:0];
    assign bitExp   = learnPattern[bitIdx];
    assign mismatch = |((phaseSample[p*LANES +: LANES] ^ {LANES{bitExp}}) & laneMask);

    always_ff @(posedge clk) begin
      if (!rstN || strobe.clearAll) begin
        beatCnt <= '0;
        badQ    <= 1'b0;
      end else if (strobe.beatEnable && phaseStrobe[p] && (beatCnt < CNT_FULL)) begin
        beatCnt <= beatCnt + 1'b1;
        badQ    <= badQ | mismatch;
      end
    end

    assign phasePass[p] = (beatCnt == CNT_FULL) && !badQ;

    // R5: the beat counter never passes the pattern length
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
      beatCnt <= CNT_FULL);
  end

  // Pass bitmap
  always_ff @(posedge clk) begin
    if (!rstN)                passMap <= '0;
    else if (strobe.latchMap) passMap <= phasePass;
  end

  // Longest-run scan
  logic [LEN_W-1:0] curLen, bestLen, runLenNext;
  logic [PH_W-1:0]  curStart, bestStart, runStartNext;

  assign runLenNext   = curLen + 1'b1;
  assign runStartNext = (curLen == '0) ? scanIdx : curStart;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.scanInit) begin
      curLen    <= '0;
      curStart  <= '0;
      bestLen   <= '0;
      bestStart <= '0;
    end else if (strobe.scanStep) begin
      if (passMap[scanIdx]) begin
        curLen   <= runLenNext;
        curStart <= runStartNext;
        if (runLenNext > bestLen) begin
          bestLen   <= runLenNext;
          bestStart <= runStartNext;
        end
      end else begin
        curLen <= '0;
      end
    end
  end

  // Commit
  logic [LEN_W-1:0] halfSpan;
  assign halfSpan = (bestLen - 1'b1) >> 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chosenPhase <= PH_W'(DEFAULT_PHASE);
      errFlag     <= 1'b0;
    end else if (strobe.commit) begin
      if (bestLen != '0) begin
        chosenPhase <= bestStart + halfSpan[PH_W-1:0];
        errFlag     <= 1'b0;
      end else begin
        errFlag <= 1'b1;
      end
    end
  end

  // R2: a clear leaves no phase passing
  a_r2_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (phasePass == '0));

  // R6: the bitmap changes only on a latch
  a_r6_map_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchMap |=> $stable(passMap));

  // R7: a successful commit lands on a passing phase
  a_r7_phase_passes: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && bestLen != '0) |=> (passMap[chosenPhase] && !errFlag));

  // R8: an empty bitmap flags an error and keeps the phase
  a_r8_keep_phase: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && passMap == '0) |=> (errFlag && $stable(chosenPhase)));

endmodule

// File: rtl/eye_trainer.sv
module eye_trainer
  import eye_trainer_pkg::*;
#(
  parameter int NPH           = 16,
  parameter int LANES         = 4,
  parameter int DEFAULT_PHASE = 8,
  parameter int PH_W          = $clog2(NPH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 trainStart,
  input  logic                 trainEnd,
  input  logic [PAT_W-1:0]     learnPattern,
  input  logic [1:0]           laneMode,
  input  logic [NPH-1:0]       phaseStrobe,
  input  logic [NPH*LANES-1:0] phaseSample,
  output logic [NPH-1:0]       passMap,
  output logic [PH_W-1:0]      chosenPhase,
  output logic                 errFlag,
  output logic                 trainDone
);

  ctrlStrobe_t     strobe;
  logic [PH_W-1:0] scanIdx;

  eye_trainer_ctrl #(.NPH(NPH), .PH_W(PH_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .trainStart (trainStart),
    .trainEnd   (trainEnd),
    .strobe     (strobe),
    .scanIdx    (scanIdx),
    .trainDone  (trainDone)
  );

  eye_trainer_dp #(
    .NPH(NPH), .LANES(LANES), .DEFAULT_PHASE(DEFAULT_PHASE), .PH_W(PH_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .scanIdx      (scanIdx),
    .learnPattern (learnPattern),
    .laneMode     (laneMode),
    .phaseStrobe  (phaseStrobe),
    .phaseSample  (phaseSample),
    .passMap      (passMap),
    .chosenPhase  (chosenPhase),
    .errFlag      (errFlag)
  );

endmodule

// File: tb/eye_trainer_tb_top.sv
module eye_trainer_tb_top;

  localparam int NPH = 16;
  localparam int LANES = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trainStart = 1'b0;
  logic trainEnd = 1'b0;
  logic [7:0] learnPattern = 8'h34;
  logic [1:0] laneMode = 2'b10;
  logic [NPH-1:0] phaseStrobe = '0;
  logic [NPH*LANES-1:0] phaseSample = '0;
  logic [NPH-1:0] passMap;
  logic [3:0] chosenPhase;
  logic errFlag;
  logic trainDone;

  int checks = 0;
  int errors = 0;
  int lastLatency = 0;
  logic [3:0] prevPhase = 4'd8;

  always #2.5 clk = ~clk;

  eye_trainer dut_i (
    .clk(clk), .rstN(rstN), .trainStart(trainStart), .trainEnd(trainEnd),
    .learnPattern(learnPattern), .laneMode(laneMode),
    .phaseStrobe(phaseStrobe), .phaseSample(phaseSample),
    .passMap(passMap), .chosenPhase(chosenPhase),
    .errFlag(errFlag), .trainDone(trainDone)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected capture phase from a bitmap; -1 when nothing passes.
  function automatic int pickPhase(input logic [NPH-1:0] m);
    int bLen = 0, bStart = 0, cLen = 0, cStart = 0;
    for (int i = 0; i < NPH; i++) begin
      if (m[i]) begin
        if (cLen == 0) cStart = i;
        cLen++;
        if (cLen > bLen) begin bLen = cLen; bStart = cStart; end
      end else cLen = 0;
    end
    return (bLen == 0) ? -1 : bStart + (bLen - 1) / 2;
  endfunction

  // One training pass; also pokes start/end during the selection (R9).
  task automatic runTrain(input logic [7:0] pat, input logic [1:0] mode,
                          input logic [NPH-1:0] corruptMask, input int cLane, input int cBeat,
                          input logic [NPH-1:0] shortMask, input bit reverse, input bit extraBeat);
    int k;
    int beats;
    learnPattern = pat;
    laneMode = mode;
    @(negedge clk) trainStart = 1'b1;
    @(negedge clk) trainStart = 1'b0;
    beats = extraBeat ? 9 : 8;
    for (int b = 0; b < beats; b++) begin
      logic e;
      e = (b == 8) ? ~pat[0] : (reverse ? pat[b] : pat[7-b]);
      for (int p = 0; p < NPH; p++) begin
        logic [LANES-1:0] v;
        v = {LANES{e}};
        if (corruptMask[p] && b == cBeat) v[cLane] = ~v[cLane];
        phaseSample[p*LANES +: LANES] = v;
        phaseStrobe[p] = !(shortMask[p] && b == 7);
      end
      @(negedge clk);
    end
    phaseStrobe = '0;
    trainEnd = 1'b1;
    @(negedge clk) trainEnd = 1'b0;
    k = 0;
    while (!trainDone && k < 100) begin
      @(posedge clk);
      @(negedge clk);
      k++;
      if (k == 3) begin trainStart = 1'b1; trainEnd = 1'b1; end
      else begin trainStart = 1'b0; trainEnd = 1'b0; end
    end
    lastLatency = k;
    @(negedge clk);
    check("R9", "done pulse width", int'(trainDone), 0);
  endtask

  task automatic checkResult(input string req, input logic [NPH-1:0] expMap);
    int ph;
    ph = pickPhase(expMap);
    check(req, "passMap", int'(passMap), int'(expMap));
    check("R9", "done latency", lastLatency, NPH + 1);
    if (ph < 0) begin
      check("R8", "errFlag set", int'(errFlag), 1);
      check("R8", "phase kept", int'(chosenPhase), int'(prevPhase));
    end else begin
      check("R7", "errFlag clear", int'(errFlag), 0);
      check("R7", "chosenPhase", int'(chosenPhase), ph);
      prevPhase = 4'(ph);
    end
  endtask

  task automatic testReset();
    check("R1", "passMap", int'(passMap), 0);
    check("R1", "chosenPhase", int'(chosenPhase), 8);
    check("R1", "errFlag", int'(errFlag), 0);
    check("R1", "trainDone", int'(trainDone), 0);
  endtask

  task automatic testAllPass();
    runTrain(8'h34, 2'b10, '0, 0, 0, '0, 1'b0, 1'b0);
    checkResult("R3", 16'hFFFF);
  endtask

  task automatic testInteriorEye();
    runTrain(8'h34, 2'b00, 16'hC03F, 0, 2, '0, 1'b0, 1'b0);
    checkResult("R6", 16'h3FC0);
  endtask

  task automatic testTie();
    runTrain(8'hA5, 2'b10, 16'hF1F1, 2, 7, '0, 1'b0, 1'b0);
    checkResult("R7", 16'h0E0E);
  endtask

  task automatic testLanes();
    runTrain(8'h34, 2'b01, 16'hFFFF, 3, 0, '0, 1'b0, 1'b0);
    checkResult("R4", 16'hFFFF);
    runTrain(8'h34, 2'b01, 16'h00FF, 1, 4, '0, 1'b0, 1'b0);
    checkResult("R4", 16'hFF00);
    runTrain(8'h34, 2'b10, 16'hFF00, 3, 5, '0, 1'b0, 1'b0);
    checkResult("R4", 16'h00FF);
    runTrain(8'h34, 2'b00, 16'hFFFF, 1, 1, '0, 1'b0, 1'b0);
    checkResult("R4", 16'hFFFF);
  endtask

  task automatic testBeatCount();
    runTrain(8'h34, 2'b10, '0, 0, 0, 16'h000F, 1'b0, 1'b0);
    checkResult("R5", 16'hFFF0);
    runTrain(8'h34, 2'b10, '0, 0, 0, '0, 1'b0, 1'b1);
    checkResult("R5", 16'hFFFF);
  endtask

  task automatic testNoPass();
    runTrain(8'h34, 2'b10, '0, 0, 0, '0, 1'b1, 1'b0);
    checkResult("R8", 16'h0000);
    runTrain(8'h5A, 2'b10, 16'h8001, 0, 3, '0, 1'b0, 1'b0);
    checkResult("R8", 16'h7FFE);
  endtask

  task automatic testIdleStrobes();
    // R2: strobes while idle must not carry into the next window.
    for (int b = 0; b < 8; b++) begin
      phaseStrobe = '1;
      phaseSample = '0;
      @(negedge clk);
    end
    phaseStrobe = '0;
    runTrain(8'h34, 2'b10, '0, 0, 0, 16'h0FFF, 1'b0, 1'b0);
    checkResult("R2", 16'hF000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAllPass();
    testInteriorEye();
    testTie();
    testLanes();
    testBeatCount();
    testNoPass();
    testIdleStrobes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule